// File: doc/BRIEF.md
# Far-End Alarm Code Dual-Word Transmitter

This block generates the serial bit stream of a far-end alarm channel, one bit per overhead bit opportunity. A single-cycle `bit_en` strobe marks each opportunity. On that strobe the downstream framer takes the bit shown on `ser_o`, and the block then moves on to the next bit. Each alarm word is 16 bits long. It starts with a flag of eight ones, then a zero, then a six-bit code, then a closing zero. When no code is requested, the channel carries continuous ones.

The host provides two six-bit codes (A and B) and a two-bit select. The select can ask for idle ones, for a continuous repeat of code A or of code B, or for one loopback command. A loopback command is a fixed run of REP_WORDS code-A words followed by REP_WORDS code-B words, after which the channel returns to idle ones and a one-cycle done pulse is raised. All selection is made only at word boundaries, so a partial word is never sent.

Top module: `feac_dual_tx`

## Requirements
- R1: While reset is asserted, and from reset until the first full word has been shifted out, `ser_o` is 1 and `done_o` is 0. The first word after reset is always sixteen ones, whatever the select value.
- R2: A code word is sent in this order: eight ones, one zero, the six code bits least significant bit first, and one zero. The flag ones occupy the first eight bit opportunities of every word.
- R3: With select 00, every word is sixteen ones.
- R4: With select 01, the block repeats code A words without a gap. With select 10, it repeats code B words.
- R5: The select and the two codes are sampled only at the bit opportunity that ends a word. A change made in the middle of a word affects only the words that follow it.
- R6: With select 11, the block sends exactly REP_WORDS code-A words and then exactly REP_WORDS code-B words. When the sequence ends and the select is no longer asking for a loopback, the next word is the one the select requests.
- R7: Once a loopback command has started, changes to the select are ignored until the last B word ends. Code values are still sampled at each word boundary.
- R8: `done_o` is high for exactly one clock cycle. That cycle directly follows the bit opportunity that consumes the last bit of the final B word of a loopback command.
- R9: A new loopback command starts only if the select has held a value other than 11 at some point since the previous command began. If it has not, the select staying at 11 gives idle ones. If it has, a new command follows the previous one with no idle word between them.
- R10: `ser_o` changes only at a clock edge on which `bit_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe for each overhead bit opportunity; the bit on `ser_o` is consumed on this edge |
| sel_i | input | 2 | Word select: 00 idle ones, 01 repeat A, 10 repeat B, 11 loopback command |
| code_a_i | input | CODE_W | Code A value |
| code_b_i | input | CODE_W | Code B value |
| ser_o | output | 1 | Bit for the current opportunity |
| done_o | output | 1 | One-cycle pulse at the end of a loopback command |

## Verification
The bench builds the block with REP_WORDS = 3 and the default CODE_W = 6. A loopback command is then only six words long, so three commands fit in a short run. These cover a command with no re-arm, which falls back to idle ones, and a re-armed command that restarts at once. It also covers a command that is left with the select set to idle. The bit strobe arrives with irregular gaps. Select and code changes are made part-way through words, which exposes any sampling outside a word boundary.

// File: rtl/feac_tx_pkg.sv
package feac_tx_pkg;

  // Number of ones at the head of every alarm word
  localparam int unsigned FLAG_ONES = 8;

  typedef enum logic [1:0] {
    SEL_IDLE   = 2'b00,
    SEL_CODE_A = 2'b01,
    SEL_CODE_B = 2'b10,
    SEL_LOOP   = 2'b11
  } feac_sel_e;

  typedef enum logic [1:0] {
    WK_ONES = 2'd0,
    WK_A    = 2'd1,
    WK_B    = 2'd2
  } word_kind_e;

  // Word length: flag ones, opening zero, code bits, closing zero
  function automatic int unsigned word_bits(input int unsigned code_w);
    return FLAG_ONES + code_w + 2;
  endfunction

endpackage

// File: rtl/feac_bit_pos.sv
module feac_bit_pos #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned PW = $clog2(WORD_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en_i,
  output logic [PW-1:0] pos_o,
  output logic          word_end_o
);

  logic [PW-1:0] pos_q;

  assign pos_o      = pos_q;
  assign word_end_o = bit_en_i && (pos_q == PW'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (bit_en_i) begin
      pos_q <= word_end_o ? '0 : pos_q + 1'b1;
    end
  end

  // R2: a word is exactly WORD_W opportunities; the position restarts after the last one
  assert_pos_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_end_o |=> (pos_q == '0));

endmodule

// File: rtl/feac_word_seq.sv
module feac_word_seq
  import feac_tx_pkg::*;
#(
  parameter int unsigned REP_WORDS = 10,
  localparam int unsigned CW = $clog2(REP_WORDS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_end_i,
  input  feac_sel_e  sel_i,
  output word_kind_e kind_o,
  output logic       done_o
);

  localparam logic [CW-1:0] LAST = CW'(REP_WORDS - 1);

  logic          lb_active_q;
  logic          lb_in_b_q;
  logic [CW-1:0] lb_cnt_q;
  logic          armed_q;
  logic          done_q;

  logic seq_last;
  logic start_loop;

  // The word now on the line is the final B word of a command
  assign seq_last   = lb_active_q && lb_in_b_q && (lb_cnt_q == LAST);
  assign start_loop = (!lb_active_q || seq_last) && (sel_i == SEL_LOOP) && armed_q;

  always_comb begin
    kind_o = WK_ONES;
    if (lb_active_q && !seq_last) begin
      kind_o = (lb_in_b_q || (lb_cnt_q == LAST)) ? WK_B : WK_A;
    end else begin
      unique case (sel_i)
        SEL_IDLE:   kind_o = WK_ONES;
        SEL_CODE_A: kind_o = WK_A;
        SEL_CODE_B: kind_o = WK_B;
        SEL_LOOP:   kind_o = armed_q ? WK_A : WK_ONES;
        default:    kind_o = WK_ONES;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_active_q <= 1'b0;
      lb_in_b_q   <= 1'b0;
      lb_cnt_q    <= '0;
      armed_q     <= 1'b1;
      done_q      <= 1'b0;
    end else begin
      done_q <= word_end_i && seq_last;
      if (sel_i != SEL_LOOP) begin
        armed_q <= 1'b1;
      end else if (word_end_i && start_loop) begin
        armed_q <= 1'b0;
      end
      if (word_end_i) begin
        if (start_loop) begin
          lb_active_q <= 1'b1;
          lb_in_b_q   <= 1'b0;
          lb_cnt_q    <= '0;
        end else if (seq_last) begin
          lb_active_q <= 1'b0;
        end else if (lb_active_q) begin
          if (lb_cnt_q == LAST) begin
            lb_in_b_q <= 1'b1;
            lb_cnt_q  <= '0;
          end else begin
            lb_cnt_q <= lb_cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign done_o = done_q;

  // R6: the word index inside a phase never passes REP_WORDS-1
  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lb_active_q |-> (lb_cnt_q <= LAST));

  // R8: the completion pulse lasts a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: a running command is not cut short by the select
  assert_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end_i && lb_active_q && !seq_last) |=> lb_active_q);

  // R9: without re-arming, the end of a command leaves the sequencer idle
  assert_no_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end_i && seq_last && !armed_q) |=> !lb_active_q);

endmodule

// File: rtl/feac_word_shift.sv
module feac_word_shift
  import feac_tx_pkg::*;
#(
  parameter int unsigned CODE_W = 6,
  localparam int unsigned WORD_W = word_bits(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en_i,
  input  logic              load_i,
  input  word_kind_e        kind_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  output logic              ser_o
);

  logic [WORD_W-1:0] sh_q;

  // Bit 0 is sent first: flag ones, zero, code LSB first, zero
  function automatic logic [WORD_W-1:0] build_word(
    input word_kind_e        k,
    input logic [CODE_W-1:0] a,
    input logic [CODE_W-1:0] b
  );
    logic [CODE_W-1:0] c;
    c = (k == WK_B) ? b : a;
    if (k == WK_ONES) return '1;
    return {1'b0, c, 1'b0, {FLAG_ONES{1'b1}}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else if (bit_en_i) begin
      sh_q <= load_i ? build_word(kind_i, code_a_i, code_b_i)
                     : {1'b1, sh_q[WORD_W-1:1]};
    end
  end

  assign ser_o = sh_q[0];

  // R10: without a bit opportunity the line bit holds
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en_i |=> $stable(ser_o));

endmodule

// File: rtl/feac_dual_tx.sv
module feac_dual_tx
  import feac_tx_pkg::*;
#(
  parameter int unsigned CODE_W    = 6,
  parameter int unsigned REP_WORDS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [1:0]        sel_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  output logic              ser_o,
  output logic              done_o
);

  localparam int unsigned WORD_W = word_bits(CODE_W);
  localparam int unsigned PW     = $clog2(WORD_W);

  logic [PW-1:0] pos;
  logic          word_end;
  word_kind_e    next_kind;

  feac_bit_pos #(.WORD_W(WORD_W)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en_i   (bit_en),
    .pos_o      (pos),
    .word_end_o (word_end)
  );

  feac_word_seq #(.REP_WORDS(REP_WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_end_i (word_end),
    .sel_i      (feac_sel_e'(sel_i)),
    .kind_o     (next_kind),
    .done_o     (done_o)
  );

  feac_word_shift #(.CODE_W(CODE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en_i (bit_en),
    .load_i   (word_end),
    .kind_i   (next_kind),
    .code_a_i (code_a_i),
    .code_b_i (code_b_i),
    .ser_o    (ser_o)
  );

  // R2: the first FLAG_ONES opportunities of every word carry ones
  assert_flag_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos < PW'(FLAG_ONES)) |-> ser_o);

  // R8: completion is reported only right after a word boundary
  assert_done_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(word_end));

endmodule

// File: tb/feac_dual_tx_test.sv
`timescale 1ns/1ps
module feac_dual_tx_test;

  localparam int REP = 3;
  localparam int CW  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_en = 1'b0;
  logic [1:0]    sel_i = 2'b01;
  logic [CW-1:0] code_a_i = 6'h2D;
  logic [CW-1:0] code_b_i = 6'h12;
  logic          ser_o;
  logic          done_o;

  always #2 clk = ~clk;

  feac_dual_tx #(.CODE_W(CW), .REP_WORDS(REP)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sel_i(sel_i),
    .code_a_i(code_a_i), .code_b_i(code_b_i), .ser_o(ser_o), .done_o(done_o)
  );

  int    compared = 0;
  int    mismatched = 0;
  bit    finished = 0;
  int    gap_seed = 0;
  logic  qb[$];
  logic  qd[$];
  string qr[$];
  logic  nd = 1'b0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // Driver side: expected bits of one word. kind 0 idle ones, otherwise flag, 0, code LSB first, 0
  task automatic push_word(input int kind, input logic [CW-1:0] code,
                           input logic last, input string req);
    for (int i = 0; i < 16; i++) begin
      logic b;
      if (kind == 0 || i < 8) b = 1'b1;
      else if (i == 8 || i == 15) b = 1'b0;
      else b = code[i-9];
      qb.push_back(b);
      qd.push_back(last && (i == 15));
      qr.push_back(req);
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); bit_en <= 1'b1;
      @(posedge clk); bit_en <= 1'b0;
      gap_seed++;
      repeat (gap_seed % 3) @(posedge clk);
    end
  endtask

  // Monitor: sampled on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (nd) begin
        compared++;
        if (done_o !== 1'b1) begin
          mismatched++;
          $display("FAIL R8 done pulse missing: actual=%b expected=1", done_o);
        end
      end else if (done_o !== 1'b0) begin
        compared++;
        mismatched++;
        $display("FAIL R8 unexpected done: actual=%b expected=0", done_o);
      end
      nd = 1'b0;
      if (bit_en) begin
        compared++;
        if (qb.size() == 0) begin
          mismatched++;
          $display("FAIL R10 bit opportunity with no expected bit: actual=%b expected=none", ser_o);
        end else begin
          logic eb; logic ed; string er;
          eb = qb.pop_front(); ed = qd.pop_front(); er = qr.pop_front();
          if (ser_o !== eb) begin
            mismatched++;
            $display("FAIL %s line bit: actual=%b expected=%b", er, ser_o, eb);
          end
          nd = ed;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    compared++;
    if (ser_o !== 1'b1 || done_o !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset outputs: actual=%b%b expected=10", ser_o, done_o);
    end
    @(posedge clk); rst_n <= 1'b1;

    // R1 first word idle even with select 01; R4 repeat A
    push_word(0, '0, 0, "R1");
    push_word(1, 6'h2D, 0, "R4");
    run(32);
    // R5: mid-word select/code change affects following words only
    push_word(1, 6'h2D, 0, "R5");
    run(5);  sel_i <= 2'b10; code_a_i <= 6'h3F;
    run(11);
    // R4 code B; R3 idle after mid-word change to 00
    push_word(2, 6'h12, 0, "R4");
    run(6);  sel_i <= 2'b00;
    run(10);
    push_word(0, '0, 0, "R3");
    run(16);
    push_word(0, '0, 0, "R3");
    run(7);  sel_i <= 2'b11; code_a_i <= 6'h05; code_b_i <= 6'h2A;
    run(9);

    // R6 first command, code B changed during A phase (sampled at boundary, R7)
    push_word(1, 6'h05, 0, "R6");
    run(8);  code_b_i <= 6'h19;
    run(8);
    push_word(1, 6'h05, 0, "R6");
    push_word(1, 6'h05, 0, "R6");
    push_word(2, 6'h19, 0, "R6");
    push_word(2, 6'h19, 0, "R6");
    push_word(2, 6'h19, 1, "R8");
    run(80);
    // R9: select stayed 11, no re-arm, so idle ones follow
    push_word(0, '0, 0, "R9");
    push_word(0, '0, 0, "R9");
    run(32);
    push_word(0, '0, 0, "R9");
    run(4);  sel_i <= 2'b00;
    run(4);  sel_i <= 2'b11;
    run(8);

    // R7: select change during the command ignored; it re-arms for R9
    push_word(1, 6'h05, 0, "R7");
    run(3);  sel_i <= 2'b10;
    run(3);  sel_i <= 2'b11;
    run(10);
    push_word(1, 6'h05, 0, "R7");
    push_word(1, 6'h05, 0, "R7");
    push_word(2, 6'h19, 0, "R7");
    push_word(2, 6'h19, 0, "R7");
    push_word(2, 6'h19, 1, "R8");
    run(80);
    // R9: re-armed command restarts with no idle word
    push_word(1, 6'h05, 0, "R9");
    run(2);  sel_i <= 2'b00;
    run(14);
    push_word(1, 6'h05, 0, "R6");
    push_word(1, 6'h05, 0, "R6");
    push_word(2, 6'h19, 0, "R6");
    push_word(2, 6'h19, 0, "R6");
    push_word(2, 6'h19, 1, "R8");
    run(80);
    // R6: after the command, select 00 gives idle ones
    push_word(0, '0, 0, "R6");
    run(16);

    repeat (4) @(negedge clk);
    compared++;
    if (qb.size() != 0) begin
      mismatched++;
      $display("FAIL R10 leftover expected bits: actual=%0d expected=0", qb.size());
    end
    finished = 1;
    summary();
    $finish;
  end

endmodule